// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps a short record of every serial frame a bit-oriented receiver finishes. It counts the bytes handed over during the frame. When the end-of-frame strobe arrives, it stores that count together with the five error/status bits of the frame as one 19-bit record, and starts the next count at zero. Records queue up to a depth of ten. DMA can keep draining the data path for back-to-back frames while the processor looks at their lengths and errors later.

The processor sees the oldest record through two register images. The low image carries the lower eight count bits. The high image carries the upper count bits, the frame status and a sticky overflow flag. Reading the high image removes the record. The queue works only while its enable input is set. While the enable is clear, both images return the ordinary register contents supplied from outside, and the whole queue stays empty. The receive data buffer is a separate block that this queue never touches.

Top module: `frmstat_queue`

## Requirements
- R1: After reset with the enable set, `fill_level` is 0, `entry_valid` is 0 and both register images read 0.
- R2: While enabled, each `byte_stb` cycle adds one to the frame byte count. An `eof_stb` cycle stores the count, including a byte strobed in the same cycle, with `eof_status`, and the count then restarts at 0. The low image is count[7:0]. The high image is count[13:8] in bits 5:0 and status in bits 10:6.
- R3: An `eof_stb` that arrives while 10 records are held, with no pop in the same cycle, is discarded. It sets the overflow flag in high-image bit 11, and that flag stays set through pops until the enable is cleared.
- R4: The byte count stops at 16383 (0x3FFF) and does not wrap.
- R5: A `rd_hi_stb` cycle while a record is held removes the oldest record. Records leave in arrival order.
- R6: With the enable set and no record held, `entry_valid` is 0, the low image is 0 and high-image bits 10:0 are 0. A `rd_hi_stb` in this state changes nothing.
- R7: While the enable is clear, the low and high images equal `reg_lo_plain` and `reg_hi_plain`. Byte, end-of-frame and pop strobes are ignored.
- R8: A clock cycle with the enable clear empties the queue, zeroes the byte count and clears the overflow flag.
- R9: The queue holds up to 10 records, and `fill_level` reports how many are held.
- R10: An end-of-frame and a pop in the same cycle on a full queue are both accepted. The level stays 10 and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_enable | input | 1 | Queue enable; clear flushes and selects the plain register views |
| byte_stb | input | 1 | One received byte in this cycle |
| eof_stb | input | 1 | Frame ended in this cycle |
| eof_status | input | 5 | Error/status bits of the ending frame |
| rd_hi_stb | input | 1 | Read strobe of the high image; pops the oldest record |
| reg_lo_plain | input | 8 | Ordinary content of the low register |
| reg_hi_plain | input | 12 | Ordinary content of the high register |
| rd_lo_data | output | 8 | Low register image |
| rd_hi_data | output | 12 | High register image |
| entry_valid | output | 1 | A record is available while enabled |
| fill_level | output | 4 | Number of records held |

## Verification
The bench aims at the full-queue edge cases.

- An eleventh frame is sent with no pop. If the design let it through, it would overwrite the oldest record. If the design failed to flag it, it would hide the loss.
- A push and a pop land in the same cycle on a full queue. A design that checks fullness without counting the pop would wrongly drop the new record.

The bench also covers the byte count itself.

- A byte strobed in the same cycle as end of frame must appear in the stored count. The count must also stop at 0x3FFF: a wrapping counter would report a long frame as a tiny one.
- A pop on an empty queue must leave the pointers alone. Corrupted pointers would show up as a wrong next record.

Finally, the bench checks the enable. Traffic sent while the enable is clear must leave no record. After a one-cycle disable, a partial count must not survive.

// File: rtl/frmstat_pkg.sv
package frmstat_pkg;

  localparam int unsigned DEF_DEPTH  = 10;
  localparam int unsigned DEF_CNT_W  = 14;
  localparam int unsigned DEF_STAT_W = 5;
  localparam int unsigned DEF_LO_W   = 8;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_PUSH = 2'b01,
    ACT_POP  = 2'b10,
    ACT_BOTH = 2'b11
  } ring_act_e;

endpackage

// File: rtl/frmstat_bytecnt.sv
module frmstat_bytecnt #(
  parameter int unsigned CNT_W = frmstat_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             byte_en,
  input  logic             frame_end,
  output logic [CNT_W-1:0] cnt_eff
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ld;

  always_comb begin
    cnt_eff = cnt_q;
    if (byte_en && (cnt_q != CNT_MAX)) begin
      cnt_eff = cnt_q + 1'b1;
    end
    cnt_ld = clear || frame_end || byte_en;
    cnt_d  = (clear || frame_end) ? '0 : cnt_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/frmstat_ring.sv
module frmstat_ring #(
  parameter int unsigned DEPTH = frmstat_pkg::DEF_DEPTH,
  parameter int unsigned W     = 19,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          dropped
);

  import frmstat_pkg::*;

  logic [PW-1:0]      wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]      rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]      level_q, level_d;
  logic               full, pop_ok, push_ok;
  ring_act_e          act;
  logic [DEPTH*W-1:0] slots_flat;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    ptr_step = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (level_q == '0);
    full    = (level_q == LW'(DEPTH));
    pop_ok  = pop_req && !empty;
    push_ok = push_req && (!full || pop_ok);
    dropped = push_req && !push_ok;
    act     = ring_act_e'({pop_ok, push_ok});
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      case (act)
        ACT_PUSH: begin
          wr_ptr_d = ptr_step(wr_ptr_q);
          level_d  = level_q + LW'(1);
        end
        ACT_POP: begin
          rd_ptr_d = ptr_step(rd_ptr_q);
          level_d  = level_q - LW'(1);
        end
        ACT_BOTH: begin
          wr_ptr_d = ptr_step(wr_ptr_q);
          rd_ptr_d = ptr_step(rd_ptr_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [W-1:0] cell_q;
    logic         cell_we;
    assign cell_we = push_ok && !flush && (wr_ptr_q == PW'(gi));
    always_ff @(posedge clk) begin
      if (cell_we) begin
        cell_q <= wr_data;
      end
    end
    assign slots_flat[gi*W +: W] = cell_q;
  end

  assign rd_data = slots_flat[rd_ptr_q*W +: W];
  assign level   = level_q;

endmodule

// File: rtl/frmstat_view.sv
module frmstat_view #(
  parameter int unsigned CNT_W  = frmstat_pkg::DEF_CNT_W,
  parameter int unsigned STAT_W = frmstat_pkg::DEF_STAT_W,
  parameter int unsigned LO_W   = frmstat_pkg::DEF_LO_W,
  localparam int unsigned HI_W  = CNT_W - LO_W + STAT_W + 1
) (
  input  logic              enable,
  input  logic              empty,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  head_cnt,
  input  logic [STAT_W-1:0] head_stat,
  input  logic [LO_W-1:0]   plain_lo,
  input  logic [HI_W-1:0]   plain_hi,
  output logic [LO_W-1:0]   view_lo,
  output logic [HI_W-1:0]   view_hi
);

  always_comb begin
    if (!enable) begin
      view_lo = plain_lo;
      view_hi = plain_hi;
    end else if (empty) begin
      view_lo = '0;
      view_hi = {ovf, {(HI_W-1){1'b0}}};
    end else begin
      view_lo = head_cnt[LO_W-1:0];
      view_hi = {ovf, head_stat, head_cnt[CNT_W-1:LO_W]};
    end
  end

endmodule

// File: rtl/frmstat_queue.sv
module frmstat_queue #(
  parameter int unsigned DEPTH  = frmstat_pkg::DEF_DEPTH,
  parameter int unsigned CNT_W  = frmstat_pkg::DEF_CNT_W,
  parameter int unsigned STAT_W = frmstat_pkg::DEF_STAT_W,
  parameter int unsigned LO_W   = frmstat_pkg::DEF_LO_W,
  localparam int unsigned HI_W  = CNT_W - LO_W + STAT_W + 1,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_enable,
  input  logic              byte_stb,
  input  logic              eof_stb,
  input  logic [STAT_W-1:0] eof_status,
  input  logic              rd_hi_stb,
  input  logic [LO_W-1:0]   reg_lo_plain,
  input  logic [HI_W-1:0]   reg_hi_plain,
  output logic [LO_W-1:0]   rd_lo_data,
  output logic [HI_W-1:0]   rd_hi_data,
  output logic              entry_valid,
  output logic [LW-1:0]     fill_level
);

  localparam int unsigned REC_W = CNT_W + STAT_W;

  logic              rst_meta_q;
  logic              rst_int_n;
  logic              flush, byte_en, eof_en, pop_en;
  logic [CNT_W-1:0]  cnt_eff;
  logic [REC_W-1:0]  rec_in, rec_head;
  logic              ring_empty, ring_drop;
  logic              ovf_q, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  always_comb begin
    flush   = !q_enable;
    byte_en = q_enable && byte_stb;
    eof_en  = q_enable && eof_stb;
    pop_en  = q_enable && rd_hi_stb;
    rec_in  = {eof_status, cnt_eff};
  end

  frmstat_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (flush),
    .byte_en   (byte_en),
    .frame_end (eof_en),
    .cnt_eff   (cnt_eff)
  );

  frmstat_ring #(.DEPTH(DEPTH), .W(REC_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flush    (flush),
    .push_req (eof_en),
    .pop_req  (pop_en),
    .wr_data  (rec_in),
    .rd_data  (rec_head),
    .level    (fill_level),
    .empty    (ring_empty),
    .dropped  (ring_drop)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (flush) begin
      ovf_d = 1'b0;
    end else if (ring_drop) begin
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  frmstat_view #(.CNT_W(CNT_W), .STAT_W(STAT_W), .LO_W(LO_W)) u_view (
    .enable    (q_enable),
    .empty     (ring_empty),
    .ovf       (ovf_q),
    .head_cnt  (rec_head[CNT_W-1:0]),
    .head_stat (rec_head[REC_W-1:CNT_W]),
    .plain_lo  (reg_lo_plain),
    .plain_hi  (reg_hi_plain),
    .view_lo   (rd_lo_data),
    .view_hi   (rd_hi_data)
  );

  assign entry_valid = q_enable && !ring_empty;

endmodule

// File: rtl/frmstat_queue_chk.sv
module frmstat_queue_chk #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned LO_W  = 8,
  parameter int unsigned HI_W  = 12,
  parameter int unsigned LW    = 4
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic            q_enable,
  input logic            eof_stb,
  input logic            rd_hi_stb,
  input logic [LO_W-1:0] rd_lo_data,
  input logic [HI_W-1:0] rd_hi_data,
  input logic [LO_W-1:0] reg_lo_plain,
  input logic [HI_W-1:0] reg_hi_plain,
  input logic            entry_valid,
  input logic [LW-1:0]   fill_level
);

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    fill_level <= LW'(DEPTH));

  assert_grow_on_end_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_enable && eof_stb && !rd_hi_stb && fill_level < LW'(DEPTH))
    |=> fill_level == $past(fill_level) + LW'(1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_enable && eof_stb && !rd_hi_stb && fill_level == LW'(DEPTH))
    |=> (fill_level == LW'(DEPTH)) && (!q_enable || rd_hi_data[HI_W-1]));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_enable && $past(q_enable) && $past(rd_hi_data[HI_W-1]))
    |-> rd_hi_data[HI_W-1]);

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_enable && rd_hi_stb && !eof_stb && fill_level == '0) |=> fill_level == '0);

  assert_empty_view_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_enable && fill_level == '0)
    |-> !entry_valid && rd_lo_data == '0 && rd_hi_data[HI_W-2:0] == '0);

  assert_plain_view_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !q_enable |-> rd_lo_data == reg_lo_plain && rd_hi_data == reg_hi_plain);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !q_enable |=> fill_level == '0);

  assert_both_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_enable && eof_stb && rd_hi_stb && fill_level != '0)
    |=> fill_level == $past(fill_level));

endmodule

bind frmstat_queue frmstat_queue_chk #(
  .DEPTH(DEPTH), .LO_W(LO_W), .HI_W(HI_W), .LW(LW)
) u_chk (.*);

// File: tb/test_frmstat_queue.sv
`timescale 1ns/1ps
module test_frmstat_queue;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        q_enable;
  logic        byte_stb;
  logic        eof_stb;
  logic [4:0]  eof_status;
  logic        rd_hi_stb;
  logic [7:0]  reg_lo_plain;
  logic [11:0] reg_hi_plain;
  logic [7:0]  rd_lo_data;
  logic [11:0] rd_hi_data;
  logic        entry_valid;
  logic [3:0]  fill_level;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  frmstat_queue i_frmstat_queue (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .byte_stb(byte_stb),
    .eof_stb(eof_stb), .eof_status(eof_status), .rd_hi_stb(rd_hi_stb),
    .reg_lo_plain(reg_lo_plain), .reg_hi_plain(reg_hi_plain),
    .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data),
    .entry_valid(entry_valid), .fill_level(fill_level)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [11:0] hi_img(input logic ovf, input logic [4:0] st, input int cnt);
    hi_img = {ovf, st, 6'(cnt >> 8)};
  endfunction

  task automatic step(input logic b, input logic e, input logic [4:0] st, input logic p);
    byte_stb = b; eof_stb = e; eof_status = st; rd_hi_stb = p;
    @(negedge clk);
    byte_stb = 1'b0; eof_stb = 1'b0; eof_status = '0; rd_hi_stb = 1'b0;
  endtask

  task automatic send_bytes(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0, 5'h0, 1'b0);
  endtask

  task automatic frame(input int n, input logic [4:0] st);
    send_bytes(n);
    step(1'b0, 1'b1, st, 1'b0);
  endtask

  task automatic pop_one();
    step(1'b0, 1'b0, 5'h0, 1'b1);
  endtask

  task automatic disable_cycle();
    q_enable = 1'b0;
    @(negedge clk);
    q_enable = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 level", 32'(fill_level), 0);
    chk("R1 valid", 32'(entry_valid), 0);
    chk("R1 lo", 32'(rd_lo_data), 0);
    chk("R1 hi", 32'(rd_hi_data), 0);
  endtask

  task automatic t_basic();
    frame(3, 5'h15);
    frame(0, 5'h0A);
    send_bytes(299);
    step(1'b1, 1'b1, 5'h01, 1'b0);
    chk("R9 level after three", 32'(fill_level), 3);
    chk("R2 valid", 32'(entry_valid), 1);
    chk("R2 lo first", 32'(rd_lo_data), 3);
    chk("R2 hi first", 32'(rd_hi_data), 32'(hi_img(1'b0, 5'h15, 3)));
    pop_one();
    chk("R5 lo second", 32'(rd_lo_data), 0);
    chk("R5 hi second", 32'(rd_hi_data), 32'(hi_img(1'b0, 5'h0A, 0)));
    pop_one();
    chk("R2 lo same-cycle byte", 32'(rd_lo_data), 32'(300 & 255));
    chk("R2 hi same-cycle byte", 32'(rd_hi_data), 32'(hi_img(1'b0, 5'h01, 300)));
    pop_one();
    chk("R6 valid empty", 32'(entry_valid), 0);
    chk("R6 hi empty", 32'(rd_hi_data), 0);
  endtask

  task automatic t_empty_pop();
    pop_one();
    pop_one();
    chk("R6 level after empty pop", 32'(fill_level), 0);
    frame(2, 5'h04);
    chk("R6 level", 32'(fill_level), 1);
    chk("R6 lo after empty pop", 32'(rd_lo_data), 2);
    chk("R6 hi after empty pop", 32'(rd_hi_data), 32'(hi_img(1'b0, 5'h04, 2)));
    disable_cycle();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 10; i++) frame(i + 1, 5'(i));
    chk("R9 full level", 32'(fill_level), 10);
    chk("R3 no flag yet", 32'(rd_hi_data[11]), 0);
    frame(99, 5'h1F);
    chk("R3 level after drop", 32'(fill_level), 10);
    chk("R3 flag set", 32'(rd_hi_data[11]), 1);
    for (int i = 0; i < 10; i++) begin
      chk("R3 kept record lo", 32'(rd_lo_data), 32'(i + 1));
      chk("R3 kept record hi", 32'(rd_hi_data), 32'(hi_img(1'b1, 5'(i), i + 1)));
      pop_one();
    end
    chk("R3 flag on empty", 32'(rd_hi_data), 32'h800);
    disable_cycle();
    chk("R8 flag cleared", 32'(rd_hi_data), 0);
  endtask

  task automatic t_full_both();
    for (int i = 0; i < 10; i++) frame(i + 1, 5'h0);
    send_bytes(7);
    step(1'b0, 1'b1, 5'h03, 1'b1);
    chk("R10 level held", 32'(fill_level), 10);
    chk("R10 no flag", 32'(rd_hi_data[11]), 0);
    chk("R10 head lo", 32'(rd_lo_data), 2);
    for (int i = 0; i < 9; i++) pop_one();
    chk("R10 new record lo", 32'(rd_lo_data), 7);
    chk("R10 new record hi", 32'(rd_hi_data), 32'(hi_img(1'b0, 5'h03, 7)));
    disable_cycle();
  endtask

  task automatic t_plain();
    q_enable = 1'b0;
    reg_lo_plain = 8'hA5;
    reg_hi_plain = 12'hBCD;
    #1;
    chk("R7 lo plain", 32'(rd_lo_data), 32'hA5);
    chk("R7 hi plain", 32'(rd_hi_data), 32'hBCD);
    @(negedge clk);
    send_bytes(3);
    step(1'b0, 1'b1, 5'h02, 1'b0);
    pop_one();
    chk("R7 level while off", 32'(fill_level), 0);
    chk("R7 valid while off", 32'(entry_valid), 0);
    q_enable = 1'b1;
    step(1'b0, 1'b1, 5'h1F, 1'b0);
    chk("R7 count not advanced", 32'(rd_lo_data), 0);
    chk("R7 hi after enable", 32'(rd_hi_data), 32'(hi_img(1'b0, 5'h1F, 0)));
    pop_one();
  endtask

  task automatic t_flush();
    frame(5, 5'h02);
    send_bytes(4);
    chk("R8 level before", 32'(fill_level), 1);
    disable_cycle();
    chk("R8 level flushed", 32'(fill_level), 0);
    chk("R8 valid flushed", 32'(entry_valid), 0);
    step(1'b0, 1'b1, 5'h0, 1'b0);
    chk("R8 count reset", 32'(rd_lo_data), 0);
    chk("R8 single record", 32'(fill_level), 1);
    pop_one();
  endtask

  task automatic t_saturate();
    send_bytes(16390);
    step(1'b0, 1'b1, 5'h0, 1'b0);
    chk("R4 lo saturated", 32'(rd_lo_data), 32'hFF);
    chk("R4 hi saturated", 32'(rd_hi_data), 32'h03F);
    pop_one();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; q_enable = 1'b1; byte_stb = 1'b0; eof_stb = 1'b0;
    eof_status = '0; rd_hi_stb = 1'b0; reg_lo_plain = 8'h00; reg_hi_plain = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_empty_pop();
    t_overflow();
    t_full_both();
    t_plain();
    t_flush();
    t_saturate();
    report();
    $finish;
  end

endmodule